// File: doc/BRIEF.md
# Diagnostic ADC Conversion Sequencer

This block sequences a single-channel, 8-bit successive-approximation conversion for on-chip diagnostics. The host writes a 5-bit channel number to start a conversion. The block then steers the analog channel mux, holds one cycle for sampling and walks the bit trials from MSB to LSB against a comparator input that reports whether the sampled voltage is at or above the trial DAC code. When the last trial finishes, the result register is loaded and a done flag is raised.

Reading the result clears the flag and starts a fresh conversion on the same channel, so a host that polls by reading gets back-to-back results. A new channel write takes effect at once: any conversion in progress is dropped and the new channel starts from the sample cycle. The comparator, the DAC, the mux itself and the scaling of codes into physical units are outside this block.

Both host-facing request channels use valid/ready, but `ready` is tied high: a request is taken on every cycle in which its valid is high, and the host never sees back-pressure. The read response is a one-cycle `res_rsp_valid` pulse that cannot be stalled, so the host must take it in that cycle.

Top module: `adc_diag_seq`

## Requirements
- R1: Out of reset, `done_flag`, `busy`, `sample` and `res_rsp_valid` are 0, `mux_sel` is 0 and the stored result is 0, so the first read returns 0.
- R2: A channel write (`chan_wr_valid` high at a rising edge, `chan_wr_ready` always 1) loads the 5-bit channel onto `mux_sel`, clears `done_flag` and raises `busy` from the next cycle on.
- R3: A conversion spends one cycle with `sample` high and then 8 trial cycles. `done_flag` rises and `busy` falls at the 9th rising edge after the starting edge.
- R4: Trials run MSB first. A bit is kept when `cmp_in` is 1, meaning the input is at or above `dac_code`, and `dac_code` equals the kept bits plus the bit under trial. With an ideal comparator the result equals the input code, including 0x00 and 0xFF.
- R5: A read (`res_rd_valid` high at an edge, `res_rd_ready` always 1) gives `res_rsp_valid` high for exactly the next cycle with the stored result on `res_rsp_data`. It clears `done_flag` and restarts a conversion on the current channel.
- R6: A read at the same edge at which a conversion completes returns the newly converted code, leaves `done_flag` at 0 and starts the next conversion.
- R7: A channel write during a conversion abandons it and restarts on the new channel. This also applies to a write at the completing edge. An abandoned conversion never sets `done_flag` and never changes the stored result.
- R8: When a write and a read arrive at the same edge, the new channel is used for the restart, and the response carries the result stored before that edge.
- R9: `mux_sel` changes only at an edge that accepts a channel write. In particular it stays stable for the whole of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_wr_valid | input | 1 | Channel write request |
| chan_wr_ready | output | 1 | Always 1: write accepted every cycle |
| chan_wr_data | input | 5 | Channel number to convert |
| res_rd_valid | input | 1 | Result read request |
| res_rd_ready | output | 1 | Always 1: read accepted every cycle |
| res_rsp_valid | output | 1 | One-cycle read response strobe |
| res_rsp_data | output | 8 | Result returned by the read |
| done_flag | output | 1 | Set when a conversion completes |
| busy | output | 1 | Conversion in progress |
| sample | output | 1 | Sample cycle of the conversion |
| mux_sel | output | 5 | Channel select to the analog mux |
| dac_code | output | 8 | Trial code to the DAC |
| cmp_in | input | 1 | Comparator: 1 when input >= DAC level |

## Verification
The comparator is modelled as an ideal compare of a per-channel input code against `dac_code`. Input codes of 0x00, 0xFF, 0x80 and 0x7F separate a trial order or keep rule that is wrong only at one end of the range. Randomly chosen channels and codes expose a mux select that follows the wrong register. Several timing patterns are run: writes that land mid-conversion and on the completing edge, reads on the completing edge, and a write together with a read. These separate correct abort and restart priority from a flag or result that leaks out of an abandoned conversion. Changing a channel's input between read-triggered conversions shows whether a read really starts a new conversion or only replays the old code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SAMPLE = 2'd1,
    SEQ_TRIAL  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_core.sv
// Bit-trial register: holds the kept bits and the index of the bit under trial.
module sar_core #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] code_next,
  output logic             last
);
  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;

  logic [RES_W-1:0] acc_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] trial_mask;

  for (genvar g = 0; g < RES_W; g++) begin : g_mask
    assign trial_mask[g] = (idx_q == IDX_W'(g));
  end

  assign dac_code  = acc_q | trial_mask;
  assign code_next = cmp_in ? dac_code : acc_q;
  assign last      = (idx_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= IDX_W'(RES_W - 1);
    end else if (start) begin
      acc_q <= '0;
      idx_q <= IDX_W'(RES_W - 1);
    end else if (step) begin
      acc_q <= code_next;
      if (!last) idx_q <= idx_q - IDX_W'(1);
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
// Conversion state machine and channel register.
module seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  logic            rd_fire,
  input  logic [CH_W-1:0] wr_ch,
  input  logic            last,
  output logic            start,
  output logic            step,
  output logic            done,
  output logic            busy,
  output logic            sample,
  output logic [CH_W-1:0] ch
);
  seq_state_e state_q, state_d;

  assign start  = wr_fire | rd_fire;
  assign step   = (state_q == SEQ_TRIAL);
  assign sample = (state_q == SEQ_SAMPLE);
  assign busy   = (state_q != SEQ_IDLE);
  // a channel write at the final trial edge abandons the conversion
  assign done   = step & last & ~wr_fire;

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = SEQ_SAMPLE;
    end else begin
      case (state_q)
        SEQ_SAMPLE: state_d = SEQ_TRIAL;
        SEQ_TRIAL:  if (last) state_d = SEQ_IDLE;
        default:    state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ch      <= '0;
    end else begin
      state_q <= state_d;
      if (wr_fire) ch <= wr_ch;
    end
  end
endmodule

// File: rtl/result_regs.sv
// Result register, done flag and read response.
module result_regs #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [RES_W-1:0] code_in,
  input  logic             wr_fire,
  input  logic             rd_fire,
  output logic             flag,
  output logic             rsp_valid,
  output logic [RES_W-1:0] rsp_data
);
  logic [RES_W-1:0] result_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q  <= '0;
      flag      <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (done) result_q <= code_in;
      if (wr_fire || rd_fire) flag <= 1'b0;
      else if (done)          flag <= 1'b1;
      rsp_valid <= rd_fire;
      if (rd_fire) rsp_data <= done ? code_in : result_q;
    end
  end
endmodule

// File: rtl/adc_diag_seq.sv
module adc_diag_seq #(
  parameter int CH_W  = 5,
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_wr_valid,
  output logic             chan_wr_ready,
  input  logic [CH_W-1:0]  chan_wr_data,
  input  logic             res_rd_valid,
  output logic             res_rd_ready,
  output logic             res_rsp_valid,
  output logic [RES_W-1:0] res_rsp_data,
  output logic             done_flag,
  output logic             busy,
  output logic             sample,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_in
);
  logic wr_fire, rd_fire, start, step, done, last;
  logic [RES_W-1:0] code_next;

  assign chan_wr_ready = 1'b1;
  assign res_rd_ready  = 1'b1;
  assign wr_fire = chan_wr_valid & chan_wr_ready;
  assign rd_fire = res_rd_valid & res_rd_ready;

  seq_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wr_ch(chan_wr_data), .last(last), .start(start), .step(step),
    .done(done), .busy(busy), .sample(sample), .ch(mux_sel)
  );

  sar_core #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step), .cmp_in(cmp_in),
    .dac_code(dac_code), .code_next(code_next), .last(last)
  );

  result_regs #(.RES_W(RES_W)) u_res (
    .clk(clk), .rst_n(rst_n), .done(done), .code_in(code_next),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .flag(done_flag),
    .rsp_valid(res_rsp_valid), .rsp_data(res_rsp_data)
  );
endmodule

// File: rtl/adc_diag_seq_chk.sv
module adc_diag_seq_chk #(
  parameter int CH_W  = 5,
  parameter int RES_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            chan_wr_valid,
  input logic [CH_W-1:0] chan_wr_data,
  input logic            res_rd_valid,
  input logic            res_rsp_valid,
  input logic            done_flag,
  input logic            busy,
  input logic            sample,
  input logic [CH_W-1:0] mux_sel
);
  localparam int CNT_W = $clog2(RES_W + 4) + 1;
  logic [CNT_W-1:0] since_start;

  // edges since the starting edge, counted while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_start <= '0;
    else if (chan_wr_valid || res_rd_valid) since_start <= CNT_W'(1);
    else if (busy && since_start != '1) since_start <= since_start + CNT_W'(1);
  end

  // R2
  wr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_wr_valid |=> busy && !done_flag && mux_sel == $past(chan_wr_data));
  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> !busy && since_start == CNT_W'(RES_W + 2));
  // R3
  one_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !chan_wr_valid && !res_rd_valid) |=> !sample && busy);
  // R5
  rd_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd_valid |=> res_rsp_valid && busy && !done_flag);
  // R5
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_rd_valid |=> !res_rsp_valid);
  // R9
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_wr_valid |=> $stable(mux_sel));
endmodule

bind adc_diag_seq adc_diag_seq_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_wr_valid(chan_wr_valid),
  .chan_wr_data(chan_wr_data), .res_rd_valid(res_rd_valid),
  .res_rsp_valid(res_rsp_valid), .done_flag(done_flag), .busy(busy),
  .sample(sample), .mux_sel(mux_sel)
);

// File: tb/adc_diag_seq_tb.sv
module adc_diag_seq_tb;
  localparam int CH_W = 5;
  localparam int RES_W = 8;
  localparam int LAT = RES_W + 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, chan_wr_valid, chan_wr_ready, res_rd_valid, res_rd_ready;
  logic res_rsp_valid, done_flag, busy, sample, cmp_in;
  logic [CH_W-1:0] chan_wr_data, mux_sel;
  logic [RES_W-1:0] res_rsp_data, dac_code;
  logic [RES_W-1:0] vin [32];

  int checks = 0;
  int fails = 0;

  assign cmp_in = (vin[mux_sel] >= dac_code);

  adc_diag_seq #(.CH_W(CH_W), .RES_W(RES_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_wr_valid(chan_wr_valid),
    .chan_wr_ready(chan_wr_ready), .chan_wr_data(chan_wr_data),
    .res_rd_valid(res_rd_valid), .res_rd_ready(res_rd_ready),
    .res_rsp_valid(res_rsp_valid), .res_rsp_data(res_rsp_data),
    .done_flag(done_flag), .busy(busy), .sample(sample),
    .mux_sel(mux_sel), .dac_code(dac_code), .cmp_in(cmp_in)
  );

  // expected code from MSB-first trials with an ideal comparator
  function automatic logic [RES_W-1:0] sar_expect(input logic [RES_W-1:0] v);
    logic [RES_W-1:0] acc = '0;
    for (int b = RES_W - 1; b >= 0; b--) begin
      logic [RES_W-1:0] t = acc | (RES_W'(1) << b);
      if (v >= t) acc = t;
    end
    return acc;
  endfunction

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [CH_W-1:0] ch);
    @(negedge clk); chan_wr_valid = 1'b1; chan_wr_data = ch;
    @(negedge clk); chan_wr_valid = 1'b0;
  endtask

  task automatic do_read(output logic [RES_W-1:0] d);
    @(negedge clk); res_rd_valid = 1'b1;
    @(negedge clk); res_rd_valid = 1'b0;
    d = res_rsp_data;
    check_eq("R5", "rsp_valid", int'(res_rsp_valid), 1);
  endtask

  // called at the first negedge after the starting edge
  task automatic wait_done(output int lat);
    lat = 1;
    while (!done_flag && lat < 40) begin
      @(negedge clk); lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [RES_W-1:0] d;
    int lat;
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) vin[i] = RES_W'(i * 7 + 3);
    rst_n = 1'b0; chan_wr_valid = 1'b0; chan_wr_data = '0; res_rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1", "flag", int'(done_flag), 0);
    check_eq("R1", "busy", int'(busy), 0);
    check_eq("R1", "rsp_valid", int'(res_rsp_valid), 0);
    check_eq("R1", "mux_sel", int'(mux_sel), 0);
    rst_n = 1'b1;
    check_eq("R2", "wr_ready", int'(chan_wr_ready), 1);
    check_eq("R5", "rd_ready", int'(res_rd_ready), 1);
    do_read(d);
    check_eq("R1", "first read", int'(d), 0);
    wait_done(lat);
    check_eq("R5", "read-start latency", lat, LAT);

    // R2 R3 R4 basic write
    vin[3] = 8'hA5;
    do_write(5'd3);
    check_eq("R2", "mux_sel", int'(mux_sel), 3);
    check_eq("R2", "busy", int'(busy), 1);
    check_eq("R2", "flag cleared", int'(done_flag), 0);
    check_eq("R3", "sample", int'(sample), 1);
    @(negedge clk);
    check_eq("R3", "sample once", int'(sample), 0);
    check_eq("R4", "MSB trial", int'(dac_code), 8'h80);
    @(negedge clk);
    check_eq("R4", "second trial", int'(dac_code), 8'hC0);
    lat = 3;
    while (!done_flag && lat < 40) begin @(negedge clk); lat++; end
    check_eq("R3", "latency", lat, LAT);
    check_eq("R3", "busy off", int'(busy), 0);
    do_read(d);
    check_eq("R4", "code", int'(d), int'(sar_expect(8'hA5)));
    check_eq("R5", "flag cleared", int'(done_flag), 0);
    check_eq("R5", "restart busy", int'(busy), 1);
    // R5 restart on same channel sees new input
    vin[3] = 8'h5A;
    wait_done(lat);
    check_eq("R5", "restart latency", lat, LAT);
    do_read(d);
    check_eq("R5", "new conversion", int'(d), 8'h5A);
    wait_done(lat);

    // R4 end codes
    vin[9] = 8'h00; vin[10] = 8'hFF; vin[11] = 8'h80; vin[12] = 8'h7F;
    for (int c = 9; c <= 12; c++) begin
      do_write(CH_W'(c));
      wait_done(lat);
      do_read(d);
      check_eq("R4", "edge code", int'(d), int'(vin[c]));
      wait_done(lat);
    end

    // R7 abort mid-conversion
    vin[5] = 8'h3C; vin[7] = 8'hC3;
    do_write(5'd5);
    repeat (3) @(negedge clk);
    do_write(5'd7);
    check_eq("R7", "mux_sel", int'(mux_sel), 7);
    check_eq("R9", "sel held", int'(mux_sel), 7);
    wait_done(lat);
    check_eq("R7", "latency from second write", lat, LAT);
    do_read(d);
    check_eq("R7", "new channel code", int'(d), 8'hC3);
    wait_done(lat);

    // R7 write at completing edge: no flag, old result kept
    vin[13] = 8'h11; vin[14] = 8'h22;
    do_write(5'd13);
    repeat (7) @(negedge clk);
    do_write(5'd14);
    check_eq("R7", "aborted flag", int'(done_flag), 0);
    check_eq("R7", "busy", int'(busy), 1);
    @(negedge clk); res_rd_valid = 1'b1; chan_wr_valid = 1'b1; chan_wr_data = 5'd14;
    @(negedge clk); res_rd_valid = 1'b0; chan_wr_valid = 1'b0;
    check_eq("R7", "result unchanged", int'(res_rsp_data), 8'hC3);
    check_eq("R8", "old result", int'(res_rsp_data), 8'hC3);
    check_eq("R8", "write channel", int'(mux_sel), 14);
    wait_done(lat);
    check_eq("R8", "latency", lat, LAT);
    do_read(d);
    check_eq("R8", "code", int'(d), 8'h22);
    wait_done(lat);

    // R6 read at completing edge
    vin[20] = 8'h96;
    do_write(5'd20);
    repeat (7) @(negedge clk);
    do_read(d);
    check_eq("R6", "new code", int'(d), 8'h96);
    check_eq("R6", "flag stays low", int'(done_flag), 0);
    check_eq("R6", "restarted", int'(busy), 1);
    wait_done(lat);
    check_eq("R6", "latency", lat, LAT);

    // random channels and codes
    for (int i = 0; i < 40; i++) begin
      logic [CH_W-1:0] ch = CH_W'($urandom);
      vin[ch] = RES_W'($urandom);
      do_write(ch);
      wait_done(lat);
      check_eq("R3", "random latency", lat, LAT);
      check_eq("R9", "random sel", int'(mux_sel), int'(ch));
      do_read(d);
      check_eq("R4", "random code", int'(d), int'(sar_expect(vin[ch])));
      wait_done(lat);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule